// File: doc/BRIEF.md
# Calendar alarm comparator with pulse output

This block runs entirely on the slow timekeeping clock. It holds a set of alarm fields (minute, hour, date, day of week) and compares them with calendar counters that reach it as inputs. When all four alarm fields agree with the calendar and the alarm is enabled, it drives an active-low alarm line low for one clock cycle. If the interrupt is also enabled, it drives an active-low interrupt line low in the same cycle. The interrupt line is meant to be sensed on its falling edge.

The alarm line can also carry a periodic pulse instead of the match pulse. In that mode it pulses once per second or sixteen times per second. Both rates come from a free-running divider of the slow clock. Software uses a small write port to load the alarm fields, set the enable bits, pick the output source, and return the alarm fields to fixed defaults.

Each match event gives one pulse only. To make an alarm repeat, software writes the next alarm time after each interrupt. A bus write first lands in a one-cycle capture stage and only then updates the alarm state.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After a synchronous reset, `alarm_n` and `irq_n` are high, both enable bits are clear, the mode is match, and the alarm fields hold 00 minutes, 00 hours, date 01 and day 0 (Sunday).
- R2: Register map on `wr_addr`:
  - 0 is the BCD minute, 1 the BCD hour, 2 the BCD date, and 3 the day of week in bits 2:0 (0 = Sunday, 1 = Monday).
  - 4 is control: bit 0 is alarm enable, bit 1 is interrupt enable, and bits 3:2 select the mode (00 = match, 01 = 1 Hz, 10 = 16 Hz, 11 = match).
  - 5 is command: writing 1 to bit 0 resets the alarm fields.
  - In match mode, a pulse needs all four fields equal to the calendar inputs. A difference in any single field gives no pulse.
- R3: In match mode, `alarm_n` is low for exactly one cycle, one cycle after the match becomes true. It stays high while the calendar keeps matching.
- R4: `irq_n` goes low for one cycle in the same cycle as each `alarm_n` pulse, and only when interrupt enable is set. Otherwise it stays high.
- R5: While alarm enable is clear, `alarm_n` and `irq_n` stay high in every mode.
- R6: In 1 Hz mode, `alarm_n` gives one single-cycle low pulse every `CLK_HZ` cycles.
- R7: In 16 Hz mode, `alarm_n` gives one single-cycle low pulse every `CLK_HZ/16` cycles.
- R8: A reset-fields command sets the alarm fields to 00 minutes, 00 hours, date 01 and Sunday. Previously written values no longer match.
- R9: A write presented before clock edge E1 passes through the capture stage at E1 and updates the alarm state at E2. A resulting match pulse therefore appears on `alarm_n` after edge E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timekeeping clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| cal_min | input | 8 | Calendar minute, BCD |
| cal_hour | input | 8 | Calendar hour, BCD |
| cal_date | input | 8 | Calendar date, BCD |
| cal_dow | input | 3 | Calendar day of week |
| alarm_n | output | 1 | Active-low alarm pulse |
| irq_n | output | 1 | Active-low interrupt pulse |

## Verification
A corrupted alarm field or enable bit shows up as a missing or extra `alarm_n` pulse in the cycle just after the calendar reaches the tested value. The bench drives each field to disagree on its own, so a comparator bit that is ignored shows directly. A stuck edge detector shows as a second low cycle one cycle later. A wrong divider phase or length shows within one output period, as a wrong pulse count or spacing. A capture stage that is missing or doubled moves the first pulse by one cycle, which the latency test samples cycle by cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  typedef enum logic [1:0] {
    MODE_MATCH   = 2'b00,
    MODE_1HZ     = 2'b01,
    MODE_16HZ    = 2'b10,
    MODE_MATCH_B = 2'b11
  } out_mode_t;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DOW_W  = 3;

  localparam logic [ADDR_W-1:0] A_MIN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HOUR = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATE = 3'd2;
  localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd5;

  typedef struct packed {
    logic [DATA_W-1:0] min;
    logic [DATA_W-1:0] hour;
    logic [DATA_W-1:0] date;
    logic [DOW_W-1:0]  dow;
  } alarm_fields_t;

  typedef struct packed {
    logic      alarm_en;
    logic      irq_en;
    out_mode_t mode;
  } alarm_ctrl_t;

  localparam alarm_fields_t FIELDS_DEFAULT = '{min: 8'h00, hour: 8'h00, date: 8'h01, dow: 3'd0};

endpackage

// File: rtl/rtc_wr_capture.sv
module rtc_wr_capture #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cap_vld,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_vld  <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
    end else begin
      cap_vld  <= wr_en;
      if (wr_en) begin
        cap_addr <= wr_addr;
        cap_data <= wr_data;
      end
    end
  end

  AST_CAP_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cap_vld) else $error("capture missed a write"); // R9

endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_vld,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [DATA_W-1:0] cap_data,
  output alarm_fields_t     fields,
  output alarm_ctrl_t       ctrl
);

  logic apply_clr;
  logic unused_ctrl_bits;

  assign apply_clr        = cap_vld && (cap_addr == A_CMD) && cap_data[0];
  assign unused_ctrl_bits = ^{cap_data[DATA_W-1:4]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fields <= FIELDS_DEFAULT;
      ctrl   <= '{alarm_en: 1'b0, irq_en: 1'b0, mode: MODE_MATCH};
    end else if (apply_clr) begin
      fields <= FIELDS_DEFAULT;
    end else if (cap_vld) begin
      case (cap_addr)
        A_MIN:  fields.min  <= cap_data;
        A_HOUR: fields.hour <= cap_data;
        A_DATE: fields.date <= cap_data;
        A_DOW:  fields.dow  <= cap_data[DOW_W-1:0];
        A_CTRL: begin
          ctrl.alarm_en <= cap_data[0];
          ctrl.irq_en   <= cap_data[1];
          ctrl.mode     <= out_mode_t'(cap_data[3:2]);
        end
        default: ;
      endcase
    end
  end

  AST_CLR_LOADS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    apply_clr |=> (fields.min == 8'h00 && fields.hour == 8'h00 &&
                   fields.date == 8'h01 && fields.dow == 3'd0))
    else $error("field reset did not load defaults"); // R8

endmodule

// File: rtl/rtc_match_det.sv
module rtc_match_det
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  alarm_fields_t     fields,
  input  logic [DATA_W-1:0] cal_min,
  input  logic [DATA_W-1:0] cal_hour,
  input  logic [DATA_W-1:0] cal_date,
  input  logic [DOW_W-1:0]  cal_dow,
  output logic              hit
);

  logic eq_now;
  logic eq_prev;

  assign eq_now = enable &&
                  (fields.min  == cal_min)  &&
                  (fields.hour == cal_hour) &&
                  (fields.date == cal_date) &&
                  (fields.dow  == cal_dow);

  always_ff @(posedge clk) begin
    if (rst) eq_prev <= 1'b0;
    else     eq_prev <= eq_now;
  end

  assign hit = eq_now && !eq_prev;

  AST_HIT_ONCE: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit) else $error("match edge repeated"); // R3

endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int CLK_HZ = 32768
) (
  input  logic clk,
  input  logic rst,
  output logic tick_1hz,
  output logic tick_16hz
);

  localparam int DIV16  = CLK_HZ / 16;
  localparam int CNT_W  = $clog2(CLK_HZ);
  localparam int SUB_W  = $clog2(DIV16);

  logic [CNT_W-1:0] sec_cnt;
  logic [SUB_W-1:0] sub_cnt;

  assign tick_1hz  = (sec_cnt == CNT_W'(CLK_HZ - 1));
  assign tick_16hz = (sub_cnt == SUB_W'(DIV16 - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt <= '0;
      sub_cnt <= '0;
    end else begin
      sec_cnt <= tick_1hz  ? '0 : sec_cnt + 1'b1;
      sub_cnt <= tick_16hz ? '0 : sub_cnt + 1'b1;
    end
  end

  AST_SECOND_ON_SUBTICK: assert property (@(posedge clk) disable iff (rst)
    tick_1hz |-> tick_16hz) else $error("divider phases drifted"); // R6

  AST_SUBTICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick_16hz |=> !tick_16hz) else $error("sub tick too close"); // R7

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int CLK_HZ = 32768
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [rtc_alarm_pkg::ADDR_W-1:0] wr_addr,
  input  logic [rtc_alarm_pkg::DATA_W-1:0] wr_data,
  input  logic [rtc_alarm_pkg::DATA_W-1:0] cal_min,
  input  logic [rtc_alarm_pkg::DATA_W-1:0] cal_hour,
  input  logic [rtc_alarm_pkg::DATA_W-1:0] cal_date,
  input  logic [rtc_alarm_pkg::DOW_W-1:0]  cal_dow,
  output logic                         alarm_n,
  output logic                         irq_n
);

  logic              cap_vld;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  alarm_fields_t     fields;
  alarm_ctrl_t       ctrl;
  logic              hit;
  logic              tick_1hz;
  logic              tick_16hz;
  logic              event_c;

  rtc_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_vld(cap_vld), .cap_addr(cap_addr), .cap_data(cap_data)
  );

  rtc_alarm_regs u_regs (
    .clk(clk), .rst(rst), .cap_vld(cap_vld), .cap_addr(cap_addr),
    .cap_data(cap_data), .fields(fields), .ctrl(ctrl)
  );

  rtc_match_det u_match (
    .clk(clk), .rst(rst), .enable(ctrl.alarm_en), .fields(fields),
    .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date),
    .cal_dow(cal_dow), .hit(hit)
  );

  rtc_tick_div #(.CLK_HZ(CLK_HZ)) u_div (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_16hz(tick_16hz)
  );

  always_comb begin
    unique case (ctrl.mode)
      MODE_1HZ:  event_c = ctrl.alarm_en && tick_1hz;
      MODE_16HZ: event_c = ctrl.alarm_en && tick_16hz;
      default:   event_c = hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_n <= 1'b1;
      irq_n   <= 1'b1;
    end else begin
      alarm_n <= !event_c;
      irq_n   <= !(event_c && ctrl.irq_en);
    end
  end

  AST_ALARM_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !alarm_n |=> alarm_n) else $error("alarm low too long"); // R3

  AST_IRQ_WITH_ALARM: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> !alarm_n) else $error("irq without alarm"); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(ctrl.irq_en)) else $error("irq while masked"); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ctrl.alarm_en |=> (alarm_n && irq_n)) else $error("pulse while disabled"); // R5

endmodule

// File: tb/rtc_alarm_unit_test.sv
module rtc_alarm_unit_test;

  localparam int CLK_HZ = 256;
  localparam int DIV16  = CLK_HZ / 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cal_min = 8'h5A;
  logic [7:0] cal_hour = 8'h00;
  logic [7:0] cal_date = 8'h01;
  logic [2:0] cal_dow = 3'd0;
  logic       alarm_n;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  rtc_alarm_unit #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date), .cal_dow(cal_dow),
    .alarm_n(alarm_n), .irq_n(irq_n)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0] amin; logic [7:0] ahour; logic [7:0] adate; logic [2:0] adow;
    logic [7:0] cmin; logic [7:0] chour; logic [7:0] cdate; logic [2:0] cdow;
    logic       pulse;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'h00, 8'h12, 8'h05, 3'd1, 8'h00, 8'h12, 8'h05, 3'd1, 1'b1},
    '{8'h00, 8'h12, 8'h05, 3'd1, 8'h01, 8'h12, 8'h05, 3'd1, 1'b0},
    '{8'h00, 8'h12, 8'h05, 3'd1, 8'h00, 8'h13, 8'h05, 3'd1, 1'b0},
    '{8'h00, 8'h12, 8'h05, 3'd1, 8'h00, 8'h12, 8'h06, 3'd1, 1'b0},
    '{8'h00, 8'h12, 8'h05, 3'd1, 8'h00, 8'h12, 8'h05, 3'd2, 1'b0},
    '{8'h59, 8'h23, 8'h31, 3'd6, 8'h59, 8'h23, 8'h31, 3'd6, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic park();
    cal_min = 8'h5A;
    @(negedge clk);
  endtask

  task automatic count_pulses(input int cycles, input int period, input string req,
                              output int n_alarm, output int n_irq);
    int last = -1;
    n_alarm = 0; n_irq = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!irq_n) n_irq++;
      if (!alarm_n) begin
        n_alarm++;
        if (last >= 0) begin
          checks++;
          if (i - last != period) begin
            errors++;
            $display("FAIL %s spacing actual=%0d expected=%0d", req, i - last, period);
          end
        end
        last = i;
      end
    end
  endtask

  task automatic chk_count(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s count actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int na, ni;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset levels
    chk("R1 alarm_n", alarm_n, 1'b1);
    chk("R1 irq_n", irq_n, 1'b1);

    // R1: reset fields are 00:00 date 01 Sunday
    wr(3'd4, 8'h03);
    cal_min = 8'h00; cal_hour = 8'h00; cal_date = 8'h01; cal_dow = 3'd0;
    @(negedge clk);
    chk("R1 default match alarm_n", alarm_n, 1'b0);
    chk("R1 default match irq_n", irq_n, 1'b0);
    park();

    // R2 R3 R4: table of field patterns
    for (int v = 0; v < 6; v++) begin
      wr(3'd0, VECS[v].amin);
      wr(3'd1, VECS[v].ahour);
      wr(3'd2, VECS[v].adate);
      wr(3'd3, {5'd0, VECS[v].adow});
      cal_min = VECS[v].cmin; cal_hour = VECS[v].chour;
      cal_date = VECS[v].cdate; cal_dow = VECS[v].cdow;
      @(negedge clk);
      chk("R2 alarm_n", alarm_n, !VECS[v].pulse);
      chk("R4 irq_n", irq_n, !VECS[v].pulse);
      @(negedge clk);
      chk("R3 release", alarm_n, 1'b1);
      repeat (3) @(negedge clk);
      chk("R3 no repeat", alarm_n, 1'b1);
      park();
    end

    // R4: interrupt masked
    wr(3'd4, 8'h01);
    cal_min = 8'h59; cal_hour = 8'h23; cal_date = 8'h31; cal_dow = 3'd6;
    @(negedge clk);
    chk("R4 alarm pulses", alarm_n, 1'b0);
    chk("R4 irq masked", irq_n, 1'b1);
    park();

    // R5: disabled in match mode and 16 Hz mode
    wr(3'd4, 8'h02);
    cal_min = 8'h59;
    @(negedge clk);
    chk("R5 match disabled alarm_n", alarm_n, 1'b1);
    chk("R5 match disabled irq_n", irq_n, 1'b1);
    park();
    wr(3'd4, 8'h0A);
    count_pulses(4 * DIV16, DIV16, "R5", na, ni);
    chk_count("R5 16Hz disabled alarm", na, 0);
    chk_count("R5 16Hz disabled irq", ni, 0);

    // R8: field reset command
    wr(3'd0, 8'h15); wr(3'd1, 8'h08); wr(3'd2, 8'h20); wr(3'd3, 8'h03);
    wr(3'd5, 8'h01);
    wr(3'd4, 8'h03);
    cal_min = 8'h15; cal_hour = 8'h08; cal_date = 8'h20; cal_dow = 3'd3;
    @(negedge clk);
    chk("R8 old value cleared", alarm_n, 1'b1);
    park();
    cal_min = 8'h00; cal_hour = 8'h00; cal_date = 8'h01; cal_dow = 3'd0;
    @(negedge clk);
    chk("R8 defaults match", alarm_n, 1'b0);
    park();

    // R9: write latency, calendar already matching
    wr(3'd4, 8'h00);
    cal_min = 8'h00;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h03;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 after E1", alarm_n, 1'b1);
    @(negedge clk);
    chk("R9 after E2", alarm_n, 1'b1);
    @(negedge clk);
    chk("R9 after E3", alarm_n, 1'b0);
    park();

    // R6: 1 Hz mode
    wr(3'd4, 8'h07);
    count_pulses(2 * CLK_HZ, CLK_HZ, "R6", na, ni);
    chk_count("R6 1Hz alarm", na, 2);
    chk_count("R6 1Hz irq", ni, 2);

    // R7: 16 Hz mode
    wr(3'd4, 8'h0B);
    count_pulses(4 * DIV16, DIV16, "R7", na, ni);
    chk_count("R7 16Hz alarm", na, 4);
    chk_count("R7 16Hz irq", ni, 4);

    finish_run();
  end

endmodule